// File: doc/BRIEF.md
# One-Shot Instruction Prefix and Register-Index Extender

This block sits beside the decoder of a 16-bit accumulator-style core. A prefix write loads a 16-bit value and a 3-bit index into it. For exactly one following instruction, the block supplies two things. The low byte of the value becomes the high byte of that instruction's immediate. The index supplies the high-order bits of its source and destination register numbers. After that instruction completes, the value and the index clear themselves. Later instructions then see the short register fields and the plain 8-bit immediate, with zero above them.

The core reports each completed instruction on `instr_done`. Only those cycles use up the prefix's life, so a stalled instruction keeps its prefix. A small state machine tracks whether a prefix is live. Its two states are `PFX_IDLE` and `PFX_ARMED`. Its transitions are:
- LOAD goes from idle to armed on a write.
- RELOAD goes from armed to armed on a write.
- EXPIRE goes from armed to idle on a completed instruction with no write.
- HOLD keeps the armed state during a stall.

The full 16-bit stored value can always be read back on `rd_data`, whichever index was used to write it.

Top module: `pfx_ext`

## Requirements
- R1: After reset, `rd_data` is 0000h, `src_addr[4]` is 0, `dst_addr[4:3]` is 00 and `imm_ext[15:8]` is 00h.
- R2: A write (`wr_en` high at a clock edge) stores `wr_data`. From the next cycle `rd_data` returns that full 16-bit value, for every index 0 to 7.
- R3: While a prefix is live, `imm_ext` equals {stored[7:0], `imm8`}. Stored bits [15:8] never appear in `imm_ext`.
- R4: `src_addr` equals {index bit 0, `src_field[3:0]`}. An even index gives sources 00h–0Fh and an odd index gives 10h–1Fh.
- R5: `dst_addr` equals {index bits [2:1], `dst_field[2:0]`}. The codes map as follows: 00 gives 00h–07h, 01 gives 08h–0Fh, 10 gives 10h–17h and 11 gives 18h–1Fh.
- R6: A cycle with `instr_done` high and `wr_en` low, while a prefix is live, clears the state for the next cycle. From then on `rd_data` is 0000h, `src_addr` is {0, `src_field`}, `dst_addr` is {00, `dst_field`} and `imm_ext` is {00h, `imm8`}.
- R7: A cycle with both `instr_done` and `wr_en` low leaves the stored value and index unchanged.
- R8: A write while a prefix is live replaces both the value and the index outright, with no bits of the old pair kept.
- R9: When a write and an expiry fall in the same cycle, the write wins. The new pair is live for the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears value and index |
| wr_en | input | 1 | Prefix write strobe |
| wr_idx | input | 3 | Index used for the write |
| wr_data | input | 16 | Value written |
| instr_done | input | 1 | An instruction completes this cycle |
| src_field | input | 4 | Short source register field |
| dst_field | input | 3 | Short destination register field |
| imm8 | input | 8 | Instruction immediate byte |
| src_addr | output | 5 | Full source register number |
| dst_addr | output | 5 | Full destination register number |
| imm_ext | output | 16 | Extended immediate |
| rd_data | output | 16 | Stored prefix value read-back |

## Verification
Each of the eight indices is written with a value whose upper and lower bytes differ. The outputs are then swept over every source field and destination field, which separates the single source bit from the two destination bits and shows that bits [15:8] never leak into the immediate. Stall cycles are placed inside each sweep, so a prefix that expired early would show at once. The expiry check then tells a one-instruction life apart from a held one. Two further patterns use complementary data and indices, so that any merging is visible: a write during a stall, and a write on a completing cycle.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    typedef enum logic {
        PFX_IDLE  = 1'b0,
        PFX_ARMED = 1'b1
    } pfx_state_e;
endpackage

// File: rtl/pfx_ctrl.sv
module pfx_ctrl
    import pfx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic instr_done,
    output logic load,
    output logic clear
);
    pfx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PFX_IDLE;
        else        state_q <= state_d;
    end

    // next state: LOAD, RELOAD, EXPIRE, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PFX_IDLE: begin
                if (wr_en) state_d = PFX_ARMED;
            end
            PFX_ARMED: begin
                if (wr_en)           state_d = PFX_ARMED;
                else if (instr_done) state_d = PFX_IDLE;
                else                 state_d = PFX_ARMED;
            end
            default: state_d = PFX_IDLE;
        endcase
    end

    // strobes to the storage
    always_comb begin
        load  = 1'b0;
        clear = 1'b0;
        unique case (state_q)
            PFX_IDLE: begin
                load = wr_en;
            end
            PFX_ARMED: begin
                load  = wr_en;
                clear = instr_done && !wr_en;
            end
            default: begin
                load  = 1'b0;
                clear = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pfx_store.sv
module pfx_store #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] val_q,
    output logic [IDX_W-1:0]  idx_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
            idx_q <= '0;
        end else if (load) begin
            val_q <= wr_data;
            idx_q <= wr_idx;
        end else if (clear) begin
            val_q <= '0;
            idx_q <= '0;
        end
    end
endmodule

// File: rtl/pfx_form.sv
module pfx_form #(
    parameter int IMM_W  = 8,
    parameter int IDX_W  = 3,
    parameter int SRC_FW = 4,
    parameter int DST_FW = 3,
    localparam int SRC_AW = SRC_FW + 1,
    localparam int DST_AW = DST_FW + IDX_W - 1
) (
    input  logic [IMM_W-1:0]  pfx_byte,
    input  logic [IDX_W-1:0]  idx,
    input  logic [SRC_FW-1:0] src_field,
    input  logic [DST_FW-1:0] dst_field,
    input  logic [IMM_W-1:0]  imm8,
    output logic [SRC_AW-1:0] src_addr,
    output logic [DST_AW-1:0] dst_addr,
    output logic [2*IMM_W-1:0] imm_ext
);
    always_comb begin
        src_addr = {idx[0], src_field};
        dst_addr = {idx[IDX_W-1:1], dst_field};
        imm_ext  = {pfx_byte, imm8};
    end
endmodule

// File: rtl/pfx_ext.sv
module pfx_ext #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8,
    parameter int IDX_W  = 3,
    parameter int SRC_FW = 4,
    parameter int DST_FW = 3,
    localparam int SRC_AW = SRC_FW + 1,
    localparam int DST_AW = DST_FW + IDX_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               instr_done,
    input  logic [SRC_FW-1:0]  src_field,
    input  logic [DST_FW-1:0]  dst_field,
    input  logic [IMM_W-1:0]   imm8,
    output logic [SRC_AW-1:0]  src_addr,
    output logic [DST_AW-1:0]  dst_addr,
    output logic [2*IMM_W-1:0] imm_ext,
    output logic [DATA_W-1:0]  rd_data
);
    logic              load, clear;
    logic [DATA_W-1:0] val_q;
    logic [IDX_W-1:0]  idx_q;

    pfx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .instr_done (instr_done),
        .load       (load),
        .clear      (clear)
    );

    pfx_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .clear   (clear),
        .wr_data (wr_data),
        .wr_idx  (wr_idx),
        .val_q   (val_q),
        .idx_q   (idx_q)
    );

    pfx_form #(.IMM_W(IMM_W), .IDX_W(IDX_W), .SRC_FW(SRC_FW), .DST_FW(DST_FW)) u_form (
        .pfx_byte  (val_q[IMM_W-1:0]),
        .idx       (idx_q),
        .src_field (src_field),
        .dst_field (dst_field),
        .imm8      (imm8),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .imm_ext   (imm_ext)
    );

    assign rd_data = val_q;
endmodule

// File: rtl/pfx_ext_chk.sv
module pfx_ext_chk #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              instr_done,
    input logic              src_hi,
    input logic [IDX_W-2:0]  dst_hi,
    input logic [IMM_W-1:0]  imm_hi,
    input logic [DATA_W-1:0] rd_data
);
    // R2
    write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));

    // R3
    imm_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> imm_hi == $past(wr_data[IMM_W-1:0]));

    // R4
    src_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> src_hi == $past(wr_idx[0]));

    // R5
    dst_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> dst_hi == $past(wr_idx[IDX_W-1:1]));

    // R6
    expire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && !wr_en) |=> (rd_data == '0 && !src_hi && dst_hi == '0 && imm_hi == '0));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_done && !wr_en) |=> ($stable(rd_data) && $stable(src_hi) && $stable(dst_hi)));
endmodule

bind pfx_ext pfx_ext_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .instr_done (instr_done),
    .src_hi     (src_addr[SRC_AW-1]),
    .dst_hi     (dst_addr[DST_AW-1:DST_FW]),
    .imm_hi     (imm_ext[2*IMM_W-1:IMM_W]),
    .rd_data    (rd_data)
);

// File: tb/tb_pfx_ext.sv
module tb_pfx_ext;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        instr_done = 1'b0;
    logic [3:0]  src_field = '0;
    logic [2:0]  dst_field = '0;
    logic [7:0]  imm8 = '0;
    logic [4:0]  src_addr, dst_addr;
    logic [15:0] imm_ext, rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pfx_ext dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .instr_done(instr_done), .src_field(src_field), .dst_field(dst_field), .imm8(imm8),
        .src_addr(src_addr), .dst_addr(dst_addr), .imm_ext(imm_ext), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // full output check against an expected value/index pair
    task automatic check_all(input string req, input logic [15:0] v, input logic [2:0] ix);
        check({req, " rd_data"},  {16'h0, rd_data},  {16'h0, v});
        check({req, " src_addr"}, {27'h0, src_addr}, {27'h0, ix[0], src_field});
        check({req, " dst_addr"}, {27'h0, dst_addr}, {27'h0, ix[2:1], dst_field});
        check({req, " imm_ext"},  {16'h0, imm_ext},  {16'h0, v[7:0], imm8});
    endtask

    // drive one cycle at the negedge, wait through the posedge to the next negedge
    task automatic cycle(input logic we, input logic [2:0] ix, input logic [15:0] d, input logic dn);
        wr_en = we; wr_idx = ix; wr_data = d; instr_done = dn;
        @(negedge clk);
        wr_en = 1'b0; instr_done = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        src_field = 4'hF; dst_field = 3'h7; imm8 = 8'h5A; #1;
        check_all("R1", 16'h0, 3'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int ix = 0; ix < 8; ix++) begin
            logic [15:0] v;
            v = {8'hC0 | 8'(ix), 8'(ix * 29 + 3)};
            cycle(1'b1, 3'(ix), v, 1'b1);
            // R2: read-back for this index
            check("R2 rd_data", {16'h0, rd_data}, {16'h0, v});
            // R3/R4/R5 sweep with stall cycles between (R7)
            for (int s = 0; s < 16; s++) begin
                for (int d = 0; d < 8; d++) begin
                    src_field = 4'(s); dst_field = 3'(d); imm8 = 8'(s * 16 + d * 3);
                    #1;
                    check("R4 src_addr", {27'h0, src_addr}, {27'h0, 1'(ix % 2), 4'(s)});
                    check("R5 dst_addr", {27'h0, dst_addr}, {27'h0, 2'(ix / 2), 3'(d)});
                    check("R3 imm_ext",  {16'h0, imm_ext},  {16'h0, v[7:0], 8'(s * 16 + d * 3)});
                    @(negedge clk);
                end
            end
            check("R7 rd_data held", {16'h0, rd_data}, {16'h0, v});
            // R6: one completed instruction expires it
            cycle(1'b0, 3'h0, 16'h0, 1'b1);
            #1;
            check_all("R6", 16'h0, 3'h0);
            // R6: a further completed instruction in idle keeps it cleared
            cycle(1'b0, 3'h0, 16'h0, 1'b1);
            #1;
            check_all("R6 idle", 16'h0, 3'h0);
        end

        // R8: write during a stall replaces the old pair
        cycle(1'b1, 3'h5, 16'hF0F5, 1'b1);
        #1; check_all("R8 first", 16'hF0F5, 3'h5);
        cycle(1'b1, 3'h2, 16'h0F0A, 1'b0);
        #1; check_all("R8", 16'h0F0A, 3'h2);
        cycle(1'b0, 3'h0, 16'h0, 1'b0);
        #1; check_all("R7", 16'h0F0A, 3'h2);

        // R9: write on the expiring cycle wins
        cycle(1'b1, 3'h6, 16'h3C96, 1'b1);
        #1; check_all("R9", 16'h3C96, 3'h6);
        cycle(1'b1, 3'h1, 16'hC369, 1'b1);
        #1; check_all("R9 again", 16'hC369, 3'h1);
        cycle(1'b0, 3'h0, 16'h0, 1'b1);
        #1; check_all("R6 after R9", 16'h0, 3'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule